// File: doc/BRIEF.md
# Tick and watchdog interrupt generator

This block turns a 32.768 kHz timebase into a periodic tick interrupt and a watchdog-expired interrupt. The timebase arrives as a synchronous clock enable (`osc_en`) in the system clock domain; each enabled cycle advances a 15-bit synchronous binary counter. Counter bit 14 is brought out as a 1 Hz square wave for a real-time clock. Counter bit 8 is a 64 Hz tap, and each of its rising edges raises the tick interrupt.

The watchdog is built from the tick itself. When a new tick edge arrives while the previous tick interrupt is still pending, meaning software left a whole tick period unserviced, the watchdog-expired interrupt is raised as well. A single clear strobe drops both interrupts, and the data that accompanies the strobe is ignored. Both interrupts are level outputs meant for an interrupt controller. A watchdog expiry only raises its interrupt line: the block has no reset output of any kind.

Top module: `tick_wdog_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter and both interrupt flags, so `tick_irq`, `wdog_irq` and `rtc_1hz` are 0 after it.
- R2: The counter advances by one only on cycles where `osc_en` is 1; with `osc_en` held at 0, no tick edge occurs and no output changes other than through a clear.
- R3: `tick_irq` becomes 1 one clock after the enabled cycle in which counter bit 8 goes from 0 to 1: the first tick follows the 256th enabled cycle after reset, and later ticks follow every further 512 enabled cycles.
- R4: `tick_irq` stays at 1 until a clear strobe, across any number of idle cycles and later tick edges.
- R5: A cycle with `clr_wr` at 1 and no tick edge makes `tick_irq` and `wdog_irq` 0 on the next clock; the value on `clr_data` has no effect.
- R6: A tick edge that arrives while `tick_irq` is 1 (and `clr_wr` is 0) sets `wdog_irq` on the next clock; once set, `wdog_irq` stays 1 across later ticks until a clear strobe.
- R7: A tick edge that arrives while `tick_irq` is 0 sets only `tick_irq`; `wdog_irq` stays 0.
- R8: When `clr_wr` is 1 in the same cycle as a tick edge, the tick wins: on the next clock `tick_irq` is 1 and `wdog_irq` is 0, even if the previous tick was pending.
- R9: `rtc_1hz` equals counter bit 14: it is 0 for the first 16384 enabled cycles after reset, 1 from the 16384th, and 0 again after the 32768th when the counter wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | One-cycle enable per 32.768 kHz timebase period |
| clr_wr | input | 1 | Clear strobe for both interrupts |
| clr_data | input | DATA_W | Write data accompanying the clear, ignored |
| tick_irq | output | 1 | Tick interrupt, level |
| wdog_irq | output | 1 | Watchdog-expired interrupt, level |
| rtc_1hz | output | 1 | 1 Hz square wave, counter bit 14 |

## Verification
The counter output `rtc_1hz` changes in the same clock as the enabled edge that moves bit 14, while a tick edge is seen in the cycle after counter bit 8 rises and the interrupt flags follow one clock later, so `tick_irq` and `wdog_irq` are due two clocks after the enabled cycle that crosses the tap. A clear strobe shows on both flags one clock after it is applied. The bench drives and samples on the falling edge, runs exact counts of enabled cycles, checks the flags still low right after the crossing cycle and high one clock later, and places the clear strobe in the exact cycle where the tick edge is pending to test the priority rule.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Interrupt flag pair held by the flag register
    typedef struct packed {
        logic tick;
        logic wdog;
    } irq_flags_t;

endpackage

// File: rtl/tw_divider.sv
module tw_divider #(
    parameter int CNT_W   = 15,
    parameter int TAP_IDX = 8,
    parameter int OUT_IDX = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic tap,
    output logic slow
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap  = st_q.cnt[TAP_IDX];
    assign slow = st_q.cnt[OUT_IDX];

endmodule

// File: rtl/tw_edge.sv
module tw_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = level & ~st_q.prev;

endmodule

// File: rtl/tw_irq_flags.sv
module tw_irq_flags
    import tw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_edge,
    input  logic clr,
    output logic tick_irq,
    output logic wdog_irq
);

    irq_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (tick_edge && clr) begin
            // new tick wins over the clear; watchdog is cleared, not set
            fl_d.tick = 1'b1;
            fl_d.wdog = 1'b0;
        end else if (tick_edge) begin
            fl_d.tick = 1'b1;
            fl_d.wdog = fl_q.wdog | fl_q.tick;
        end else if (clr) begin
            fl_d.tick = 1'b0;
            fl_d.wdog = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign tick_irq = fl_q.tick;
    assign wdog_irq = fl_q.wdog;

endmodule

// File: rtl/tick_wdog_gen.sv
module tick_wdog_gen #(
    parameter int DIV_BITS = 15,
    parameter int TAP_BIT  = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_en,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_data,
    output logic              tick_irq,
    output logic              wdog_irq,
    output logic              rtc_1hz
);

    localparam int SLOW_BIT = DIV_BITS - 1;

    logic tap_lvl;
    logic tick_edge;
    logic clr_data_unused;

    // the written value carries no meaning for the clear
    assign clr_data_unused = ^clr_data;

    tw_divider #(
        .CNT_W   (DIV_BITS),
        .TAP_IDX (TAP_BIT),
        .OUT_IDX (SLOW_BIT)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .step (osc_en),
        .tap  (tap_lvl),
        .slow (rtc_1hz)
    );

    tw_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (tap_lvl),
        .rise  (tick_edge)
    );

    tw_irq_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .tick_edge (tick_edge),
        .clr       (clr_wr),
        .tick_irq  (tick_irq),
        .wdog_irq  (wdog_irq)
    );

endmodule

// File: rtl/tick_wdog_chk.sv
module tick_wdog_chk (
    input logic clk,
    input logic rst,
    input logic osc_en,
    input logic clr_wr,
    input logic tick_edge,
    input logic tick_irq,
    input logic wdog_irq,
    input logic rtc_1hz
);

    // R2
    slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> $stable(rtc_1hz));

    // R3
    tick_set_chk: assert property (@(posedge clk) disable iff (rst)
        tick_edge |=> tick_irq);

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_edge && !clr_wr) |=> ($stable(tick_irq) && $stable(wdog_irq)));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !tick_edge) |=> (!tick_irq && !wdog_irq));

    // R6
    wdog_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_edge && tick_irq && !clr_wr) |=> wdog_irq);

    // R7
    wdog_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdog_irq) |-> $past(tick_irq));

    // R8
    clear_vs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_edge && clr_wr) |=> (tick_irq && !wdog_irq));

endmodule

bind tick_wdog_gen tick_wdog_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .osc_en    (osc_en),
    .clr_wr    (clr_wr),
    .tick_edge (tick_edge),
    .tick_irq  (tick_irq),
    .wdog_irq  (wdog_irq),
    .rtc_1hz   (rtc_1hz)
);

// File: tb/tick_wdog_gen_bench.sv
module tick_wdog_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        osc_en;
    logic        clr_wr;
    logic [31:0] clr_data;
    logic        tick_irq;
    logic        wdog_irq;
    logic        rtc_1hz;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tick_wdog_gen u_tick_wdog_gen (
        .clk      (clk),
        .rst      (rst),
        .osc_en   (osc_en),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .tick_irq (tick_irq),
        .wdog_irq (wdog_irq),
        .rtc_1hz  (rtc_1hz)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_en(input int n);
        osc_en = 1'b1;
        for (int i = 0; i < n; i++) cyc();
        osc_en = 1'b0;
    endtask

    task automatic clear(input logic [31:0] data);
        clr_wr   = 1'b1;
        clr_data = data;
        cyc();
        clr_wr   = 1'b0;
        clr_data = 32'h0;
    endtask

    // counter 0 after reset
    task automatic t_reset();
        rst = 1'b1; osc_en = 1'b0; clr_wr = 1'b0; clr_data = 32'h0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R1 tick after reset", tick_irq, 1'b0);
        chk("R1 wdog after reset", wdog_irq, 1'b0);
        chk("R1 rtc_1hz after reset", rtc_1hz, 1'b0);
    endtask

    // counter reaches 256
    task automatic t_first_tick();
        run_en(255);
        cyc();
        chk("R3 no tick before 256th enable", tick_irq, 1'b0);
        run_en(1);
        chk("R3 tick not yet one clock after crossing", tick_irq, 1'b0);
        cyc();
        chk("R3 first tick", tick_irq, 1'b1);
        chk("R7 first tick leaves wdog low", wdog_irq, 1'b0);
    endtask

    task automatic t_idle_hold();
        repeat (600) cyc();
        chk("R2 R4 tick held over idle cycles", tick_irq, 1'b1);
        chk("R2 no wdog without enables", wdog_irq, 1'b0);
        chk("R2 rtc_1hz steady without enables", rtc_1hz, 1'b0);
    endtask

    task automatic t_clear_data();
        clear(32'hDEAD_BEEF);
        chk("R5 clear with data pattern drops tick", tick_irq, 1'b0);
        chk("R5 clear leaves wdog low", wdog_irq, 1'b0);
    endtask

    // counter 256 -> 768
    task automatic t_serviced();
        run_en(511);
        cyc();
        chk("R3 no tick one enable early", tick_irq, 1'b0);
        run_en(1);
        cyc();
        chk("R3 periodic tick", tick_irq, 1'b1);
        chk("R7 serviced tick leaves wdog low", wdog_irq, 1'b0);
    endtask

    // counter 768 -> 1280 -> 1792
    task automatic t_unserviced();
        run_en(512);
        chk("R6 wdog not before flag update", wdog_irq, 1'b0);
        cyc();
        chk("R6 wdog on unserviced tick", wdog_irq, 1'b1);
        chk("R4 tick still pending", tick_irq, 1'b1);
        run_en(512);
        cyc();
        chk("R6 wdog sticky across tick", wdog_irq, 1'b1);
    endtask

    task automatic t_clear_both();
        clear(32'h0000_0000);
        chk("R5 clear with zero data drops tick", tick_irq, 1'b0);
        chk("R5 clear drops wdog", wdog_irq, 1'b0);
    endtask

    // counter 1792 -> 2304 -> 2816
    task automatic t_collision();
        run_en(512);
        cyc();
        chk("R8 setup tick pending", tick_irq, 1'b1);
        run_en(512);
        clear(32'hFFFF_FFFF);
        chk("R8 tick wins over clear", tick_irq, 1'b1);
        chk("R8 wdog not set on collision", wdog_irq, 1'b0);
    endtask

    // counter 2816 -> 16384 -> 32768 (wraps to 0)
    task automatic t_slow_out();
        run_en(13567);
        chk("R9 rtc_1hz low before 16384", rtc_1hz, 1'b0);
        run_en(1);
        chk("R9 rtc_1hz high at 16384", rtc_1hz, 1'b1);
        run_en(16383);
        chk("R9 rtc_1hz high before wrap", rtc_1hz, 1'b1);
        run_en(1);
        chk("R9 rtc_1hz low after wrap", rtc_1hz, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_tick();
        t_idle_hold();
        t_clear_data();
        t_serviced();
        t_unserviced();
        t_clear_both();
        t_collision();
        t_slow_out();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule